// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block decides, one always-on clock cycle at a time, which clock and power enables are live while the processor runs, waits or stops. It keeps a small set of configuration bits: oscillator enable, pseudo-stop select, PLL select, the two watchdog clock-source select bits, the watchdog stop-disable bit and the RTI clock-source select. It combines them with a stop request and a wake-up event to produce enables for the PLL, the internal reference clock, the external oscillator and the gated core, bus and debug clocks. It also produces the regulator reduced-performance flag, the low-voltage detector enables, and run controls for the watchdog and RTI counters.

Wait is not a separate state. While the processor waits, every output matches run mode. A stop request enters full stop or pseudo stop. The choice depends on the registered oscillator-enable and pseudo-stop bits. A wake-up event returns to run on the next edge. Leaving full stop resets some clock-source selects to fixed values. The PLL-select bit can be cleared only after the oscillator is enabled and reports that it is up.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: After reset the controller is in run. The configuration reads oscillator enable 0, pseudo-stop 0, PLL select 1, watchdog select 00, stop-disable 0 and RTI select 0. The PLL, reference clock, gated clocks, low-voltage enables and both counter run controls are 1. The regulator flag and the oscillator enable are 0.
- R2: A stop request in run enters stop at the next clock edge. In stop, pll_en, irc_en and every bit of gated_clk_en are 0.
- R3: In stop, vreg_rpm is 1 and lvi_en and lvr_en are 0. In run, vreg_rpm is 0 and both detector enables are 1.
- R4: Stop is pseudo stop only when the registered oscillator-enable and pseudo-stop bits are both 1. In every other case it is full stop.
- R5: xosc_en follows the oscillator-enable bit in run and in pseudo stop. It is 0 in full stop.
- R6: In full stop, rti_run is 0. wdg_run is 0 when watchdog select bit 1 (wdg_sel[1]) is 0.
- R7: In full stop with wdg_sel[1] equal to 1, wdg_run equals the inverse of the stop-disable bit.
- R8: Leaving full stop sets PLL select to 1 and clears wdg_sel[0] and rti_sel. wdg_sel[1] keeps its value.
- R9: In pseudo stop, wdg_run and rti_run stay 1. Leaving pseudo stop leaves every select bit unchanged.
- R10: A configuration write that clears PLL select takes effect only if the registered oscillator-enable bit is 1 and osc_up is 1. Otherwise PLL select stays 1, while the other fields of the write still take effect.
- R11: A wake-up event in stop returns to run at the next edge, even when a stop request arrives in the same cycle. In run, a stop request that arrives together with a wake-up event is dropped.
- R12: While in stop, configuration writes and further stop requests have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_req | input | 1 | Stop instruction executed |
| wake_evt | input | 1 | Wake-up event |
| osc_up | input | 1 | External oscillator reports stable |
| cfg_wr | input | 1 | Write strobe for the configuration fields |
| cfg_osc_en | input | 1 | Oscillator enable write value |
| cfg_pstop_sel | input | 1 | Pseudo-stop select write value |
| cfg_pll_sel | input | 1 | PLL select write value (1 = core/bus on PLL) |
| cfg_wdg_sel | input | 2 | Watchdog clock-source select write value |
| cfg_wdg_stop_dis | input | 1 | Gate the watchdog RC clock in full stop |
| cfg_rti_sel | input | 1 | RTI clock-source select write value |
| pll_en | output | 1 | PLL enable |
| irc_en | output | 1 | Internal reference clock enable |
| xosc_en | output | 1 | External oscillator enable |
| gated_clk_en | output | GATED_CLKS | Core, bus and debug clock enables |
| vreg_rpm | output | 1 | Regulator in reduced-performance mode |
| lvi_en | output | 1 | Low-voltage interrupt detector enable |
| lvr_en | output | 1 | Low-voltage reset detector enable |
| pll_sel | output | 1 | Current PLL select |
| wdg_sel | output | 2 | Current watchdog clock-source select |
| rti_sel | output | 1 | Current RTI clock-source select |
| wdg_run | output | 1 | Watchdog counter may advance |
| rti_run | output | 1 | RTI counter may advance |

## Verification
A wake-up event and a stop request can land in the same cycle, both while the controller is stopped and while it is running. The stimulus table asserts both together in each situation. The bench expects run in both cases: from stop, the wake-up takes the controller out, and in run the stop request is dropped. A configuration write can also arrive in a stop cycle or alongside a PLL-select clear before the oscillator is up. The bench then confirms at the outputs that the select bits keep their earlier values.

// File: rtl/lpm_clk_pkg.sv
package lpm_clk_pkg;

    parameter int WDG_SEL_W = 2;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_FSTOP = 2'd1,
        MODE_PSTOP = 2'd2
    } lpm_mode_e;

    typedef struct packed {
        logic                 osc_en;
        logic                 pstop_sel;
        logic                 pll_sel;
        logic [WDG_SEL_W-1:0] wdg_sel;
        logic                 wdg_stop_dis;
        logic                 rti_sel;
    } lpm_cfg_t;

    localparam lpm_cfg_t CFG_RESET = '{
        osc_en:       1'b0,
        pstop_sel:    1'b0,
        pll_sel:      1'b1,
        wdg_sel:      '0,
        wdg_stop_dis: 1'b0,
        rti_sel:      1'b0
    };

endpackage

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
    import lpm_clk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stop_req,
    input  logic      wake_evt,
    input  logic      cfg_osc_en,
    input  logic      cfg_pstop_sel,
    output lpm_mode_e mode_q,
    output logic      wake_from_full
);

    typedef struct packed {
        lpm_mode_e mode;
    } fsm_st_t;

    fsm_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        wake_from_full = 1'b0;
        case (st_q.mode)
            MODE_RUN: begin
                // a wake-up in the same cycle cancels the stop request
                if (stop_req && !wake_evt) begin
                    st_d.mode = (cfg_osc_en && cfg_pstop_sel) ? MODE_PSTOP : MODE_FSTOP;
                end
            end
            MODE_FSTOP: begin
                if (wake_evt) begin
                    st_d.mode      = MODE_RUN;
                    wake_from_full = 1'b1;
                end
            end
            MODE_PSTOP: begin
                if (wake_evt) begin
                    st_d.mode = MODE_RUN;
                end
            end
            default: st_d.mode = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q = st_q.mode;

endmodule

// File: rtl/lpm_cfg_bank.sv
module lpm_cfg_bank
    import lpm_clk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_run,
    input  logic     cfg_wr,
    input  lpm_cfg_t cfg_in,
    input  logic     osc_up,
    input  logic     wake_from_full,
    output lpm_cfg_t cfg_q
);

    lpm_cfg_t cfg_d, cfg_r;
    logic     pll_clear_ok;

    // clearing the PLL select needs a running, stable oscillator
    assign pll_clear_ok = cfg_r.osc_en && osc_up;

    always_comb begin
        cfg_d = cfg_r;
        if (in_run && cfg_wr) begin
            cfg_d = cfg_in;
            if (!cfg_in.pll_sel && !pll_clear_ok) begin
                cfg_d.pll_sel = cfg_r.pll_sel;
            end
        end
        if (wake_from_full) begin
            cfg_d.pll_sel    = 1'b1;
            cfg_d.wdg_sel[0] = 1'b0;
            cfg_d.rti_sel    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_r <= CFG_RESET;
        end else begin
            cfg_r <= cfg_d;
        end
    end

    assign cfg_q = cfg_r;

endmodule

// File: rtl/lpm_out_decode.sv
module lpm_out_decode
    import lpm_clk_pkg::*;
#(
    parameter int GATED_CLKS = 3
) (
    input  lpm_mode_e                 mode,
    input  lpm_cfg_t                  cfg,
    output logic                      pll_en,
    output logic                      irc_en,
    output logic                      xosc_en,
    output logic [GATED_CLKS-1:0]     gated_clk_en,
    output logic                      vreg_rpm,
    output logic                      lvi_en,
    output logic                      lvr_en,
    output logic                      wdg_run,
    output logic                      rti_run
);

    localparam int WDG_RC_BIT = WDG_SEL_W - 1;

    logic is_run, is_full;

    assign is_run  = (mode == MODE_RUN);
    assign is_full = (mode == MODE_FSTOP);

    assign pll_en   = is_run;
    assign irc_en   = is_run;
    assign xosc_en  = cfg.osc_en && !is_full;
    assign vreg_rpm = !is_run;
    assign lvi_en   = is_run;
    assign lvr_en   = is_run;

    for (genvar g = 0; g < GATED_CLKS; g++) begin : g_gate
        assign gated_clk_en[g] = is_run;
    end

    always_comb begin
        wdg_run = 1'b1;
        rti_run = 1'b1;
        if (is_full) begin
            rti_run = 1'b0;
            wdg_run = cfg.wdg_sel[WDG_RC_BIT] && !cfg.wdg_stop_dis;
        end
    end

endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
    import lpm_clk_pkg::*;
#(
    parameter int GATED_CLKS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stop_req,
    input  logic                  wake_evt,
    input  logic                  osc_up,
    input  logic                  cfg_wr,
    input  logic                  cfg_osc_en,
    input  logic                  cfg_pstop_sel,
    input  logic                  cfg_pll_sel,
    input  logic [WDG_SEL_W-1:0]  cfg_wdg_sel,
    input  logic                  cfg_wdg_stop_dis,
    input  logic                  cfg_rti_sel,
    output logic                  pll_en,
    output logic                  irc_en,
    output logic                  xosc_en,
    output logic [GATED_CLKS-1:0] gated_clk_en,
    output logic                  vreg_rpm,
    output logic                  lvi_en,
    output logic                  lvr_en,
    output logic                  pll_sel,
    output logic [WDG_SEL_W-1:0]  wdg_sel,
    output logic                  rti_sel,
    output logic                  wdg_run,
    output logic                  rti_run
);

    lpm_mode_e mode_q;
    logic      wake_from_full;
    lpm_cfg_t  cfg_in, cfg_q;

    always_comb begin
        cfg_in.osc_en       = cfg_osc_en;
        cfg_in.pstop_sel    = cfg_pstop_sel;
        cfg_in.pll_sel      = cfg_pll_sel;
        cfg_in.wdg_sel      = cfg_wdg_sel;
        cfg_in.wdg_stop_dis = cfg_wdg_stop_dis;
        cfg_in.rti_sel      = cfg_rti_sel;
    end

    lpm_mode_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .stop_req       (stop_req),
        .wake_evt       (wake_evt),
        .cfg_osc_en     (cfg_q.osc_en),
        .cfg_pstop_sel  (cfg_q.pstop_sel),
        .mode_q         (mode_q),
        .wake_from_full (wake_from_full)
    );

    lpm_cfg_bank u_cfg (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_run         (mode_q == MODE_RUN),
        .cfg_wr         (cfg_wr),
        .cfg_in         (cfg_in),
        .osc_up         (osc_up),
        .wake_from_full (wake_from_full),
        .cfg_q          (cfg_q)
    );

    lpm_out_decode #(.GATED_CLKS(GATED_CLKS)) u_dec (
        .mode         (mode_q),
        .cfg          (cfg_q),
        .pll_en       (pll_en),
        .irc_en       (irc_en),
        .xosc_en      (xosc_en),
        .gated_clk_en (gated_clk_en),
        .vreg_rpm     (vreg_rpm),
        .lvi_en       (lvi_en),
        .lvr_en       (lvr_en),
        .wdg_run      (wdg_run),
        .rti_run      (rti_run)
    );

    assign pll_sel = cfg_q.pll_sel;
    assign wdg_sel = cfg_q.wdg_sel;
    assign rti_sel = cfg_q.rti_sel;

endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk #(
    parameter int GATED_CLKS = 3,
    parameter int SEL_W      = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wake_evt,
    input logic                  osc_up,
    input logic                  pll_en,
    input logic                  irc_en,
    input logic                  xosc_en,
    input logic [GATED_CLKS-1:0] gated_clk_en,
    input logic                  vreg_rpm,
    input logic                  lvi_en,
    input logic                  lvr_en,
    input logic                  pll_sel,
    input logic [SEL_W-1:0]      wdg_sel,
    input logic                  rti_sel
);

    // R2
    stop_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vreg_rpm |-> (!pll_en && !irc_en && gated_clk_en == '0));

    // R3
    stop_lvd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vreg_rpm |-> (!lvi_en && !lvr_en));

    // R11
    wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vreg_rpm && wake_evt) |=> !vreg_rpm);

    // R8
    full_wake_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vreg_rpm && !xosc_en && wake_evt) |=> (pll_sel && !wdg_sel[0] && !rti_sel));

    // R12
    stop_sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vreg_rpm && !wake_evt) |=> ($stable(pll_sel) && $stable(wdg_sel) && $stable(rti_sel)));

    // R10
    pll_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vreg_rpm && pll_sel && !osc_up) |=> pll_sel);

endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk #(.GATED_CLKS(GATED_CLKS), .SEL_W(lpm_clk_pkg::WDG_SEL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wake_evt     (wake_evt),
    .osc_up       (osc_up),
    .pll_en       (pll_en),
    .irc_en       (irc_en),
    .xosc_en      (xosc_en),
    .gated_clk_en (gated_clk_en),
    .vreg_rpm     (vreg_rpm),
    .lvi_en       (lvi_en),
    .lvr_en       (lvr_en),
    .pll_sel      (pll_sel),
    .wdg_sel      (wdg_sel),
    .rti_sel      (rti_sel)
);

// File: tb/lpm_clk_ctrl_tb_top.sv
module lpm_clk_ctrl_tb_top;

    localparam int GC = 3;
    localparam int NV = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 0, wake_evt = 0, osc_up = 0, cfg_wr = 0;
    logic cfg_osc_en = 0, cfg_pstop_sel = 0, cfg_pll_sel = 0;
    logic [1:0] cfg_wdg_sel = 0;
    logic cfg_wdg_stop_dis = 0, cfg_rti_sel = 0;
    logic pll_en, irc_en, xosc_en, vreg_rpm, lvi_en, lvr_en;
    logic pll_sel, rti_sel, wdg_run, rti_run;
    logic [1:0] wdg_sel;
    logic [GC-1:0] gated_clk_en;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lpm_clk_ctrl #(.GATED_CLKS(GC)) dut_i (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake_evt(wake_evt),
        .osc_up(osc_up), .cfg_wr(cfg_wr), .cfg_osc_en(cfg_osc_en),
        .cfg_pstop_sel(cfg_pstop_sel), .cfg_pll_sel(cfg_pll_sel),
        .cfg_wdg_sel(cfg_wdg_sel), .cfg_wdg_stop_dis(cfg_wdg_stop_dis),
        .cfg_rti_sel(cfg_rti_sel), .pll_en(pll_en), .irc_en(irc_en),
        .xosc_en(xosc_en), .gated_clk_en(gated_clk_en), .vreg_rpm(vreg_rpm),
        .lvi_en(lvi_en), .lvr_en(lvr_en), .pll_sel(pll_sel), .wdg_sel(wdg_sel),
        .rti_sel(rti_sel), .wdg_run(wdg_run), .rti_run(rti_run)
    );

    // input  [10:0]: stop wake wr osc_en pstop pll_sel wsel1 wsel0 stop_dis rti_sel osc_up
    // output [11:0]: pll_en irc_en xosc_en clk_all vreg_rpm lvi wdg_run rti_run pll_sel wsel1 wsel0 rti_sel
    localparam logic [22:0] VEC [NV] = '{
        {11'h000, 12'hD78},  // R1  idle in run
        {11'h180, 12'hF78},  // R10 clear ignored, osc still down
        {11'h19B, 12'hF77},  // R10 clear accepted, selects written
        {11'h400, 12'h0A7},  // R7  full stop, RC watchdog kept running
        {11'h100, 12'h0A7},  // R12 write in stop ignored
        {11'h200, 12'hF7C},  // R8  wake from full stop forces selects
        {11'h1E5, 12'hF78},  // R5  oscillator on in run
        {11'h400, 12'h2B8},  // R4  pseudo stop
        {11'h400, 12'h2B8},  // R12 second stop ignored
        {11'h200, 12'hF78},  // R9  wake from pseudo stop keeps selects
        {11'h1B5, 12'hF7C},  // R5  pseudo bit cleared
        {11'h400, 12'h08C},  // R7  full stop, stop-disable gates watchdog
        {11'h600, 12'hF7C},  // R11 wake and stop together in stop
        {11'h600, 12'hF7C},  // R11 wake and stop together in run
        {11'h161, 12'hD78},  // R5  oscillator disabled
        {11'h400, 12'h088},  // R6  full stop from osc_en=0
        {11'h200, 12'hD78},  // R8  wake again
        {11'h180, 12'hF78}   // R10 clear with osc down
    };

    localparam string TAG [NV] = '{
        "R1", "R10", "R10", "R7", "R12", "R8", "R5", "R4", "R12",
        "R9", "R5", "R7", "R11", "R11", "R5", "R6", "R8", "R10"
    };

    function automatic logic [11:0] observe();
        return {pll_en, irc_en, xosc_en, &gated_clk_en, vreg_rpm, lvi_en,
                wdg_run, rti_run, pll_sel, wdg_sel, rti_sel};
    endfunction

    task automatic drive(input logic [10:0] v);
        @(negedge clk);
        {stop_req, wake_evt, cfg_wr, cfg_osc_en, cfg_pstop_sel, cfg_pll_sel,
         cfg_wdg_sel, cfg_wdg_stop_dis, cfg_rti_sel, osc_up} = v;
        @(posedge clk);
        #1;
        {stop_req, wake_evt, cfg_wr} = 3'b000;
    endtask

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        #(8 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", observe(), 12'hD78);
        check("R1", {11'b0, lvr_en}, 12'h001);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][22:12]);
            check(TAG[i], observe(), VEC[i][11:0]);
        end

        // R10: osc_up high but oscillator-enable bit still 0 -> clear ignored
        drive(11'h161);
        drive(11'h101);
        check("R10", {11'b0, pll_sel}, 12'h001);

        // R2 / R3: every gated clock and both detectors off in stop
        drive(11'h400);
        check("R2", {{(12-GC){1'b0}}, gated_clk_en}, 12'h000);
        check("R3", {10'b0, lvr_en, lvi_en}, 12'h000);

        // R1: reset while stopped returns to run with reset selects
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", observe(), 12'hD78);
        @(negedge clk);
        rst_n = 1'b1;
        drive(11'h000);
        check("R1", observe(), 12'hD78);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule